// File: doc/BRIEF.md
# Twelve-Line GPIO Bank with Event Interrupts and PWM Trip

The block is a bank of twelve general-purpose lines behind a small register interface. Each line can be an input or an output. Each line also feeds an event detector that watches for an edge or a level of a chosen polarity. Lines 0 to 3 each raise their own interrupt request. Lines 4 to 11 share a single request, which is backed by a sticky per-line flag register. Software reads that register to find which line fired and then clears the flag by writing 1 to its bit.

Any line can also act as an active-low fault input for a PWM stage. When a line's trip enable is set and the raw pin is low, `pwm_shutdown` asserts at once through gates alone, so it works even when the clock has stopped. A small state machine (`TRIP_IDLE`, `TRIP_PULSE`, `TRIP_HOLD`) also turns the synchronised fault condition into a one-cycle trip interrupt. The transitions are:
- `TRIP_IDLE` moves to `TRIP_PULSE` on a fault.
- `TRIP_PULSE` moves to `TRIP_HOLD` while the fault persists.
- `TRIP_PULSE` moves to `TRIP_IDLE` if the fault is gone.
- `TRIP_HOLD` moves to `TRIP_IDLE` when the fault clears.

Pin inputs pass through a two-flop synchroniser before they are used for detection or read back. An external 5-bit mask gates the four dedicated requests (bits 0 to 3) and the shared request (bit 4).

Top module: `gpio_trip_bank`

## Requirements
- R1: After reset, all registers are zero. So every line is an input (`pin_oe`=0), edge mode with falling polarity is selected, and no trip enable is set. `irq_ded`, `irq_shared`, `irq_trip` and `pwm_shutdown` are low, and the flag register (address 5) reads 0.
- R2: Register addresses are: 0 direction (1 = output), 1 data, 2 mode, 3 polarity, 4 shared enable, 5 flags, 6 trip enable. Bit n of each register belongs to line n.
  - `pin_oe` follows the direction register, and `pin_out` follows the data register.
  - Reading address 1 returns the written value on output lines. On input lines it returns the pin as it was two clock edges earlier.
- R3: In edge mode (mode bit 0), polarity 1 selects the rising edge and 0 the falling edge. For lines 0 to 3, an edge on the pin raises `irq_ded[n]` for exactly one cycle, three clock edges after the pin changes. The opposite edge raises nothing.
- R4: In level mode (mode bit 1), polarity 1 means active high and 0 means active low. `irq_ded[n]` stays high while the level holds and drops three edges after it ends.
- R5: `irq_ded[n]` is gated by `irq_mask[n]`. It goes low one clock edge after the mask bit is cleared and returns one edge after the mask bit is set again.
- R6: For lines 4 to 11 whose shared-enable bit is set, an event sets the line's flag. `irq_shared` is `irq_mask[4]` AND (any flag set). Lines 0 to 3 never set flags, even with their shared-enable bits written to 1.
- R7: Flags are sticky and are cleared only by writing 1 to the bit at address 5. An event in the same cycle as the clear wins, so the flag stays set. A level condition that is still active sets the flag again at once.
- R8: A line set as an output feeds its own driven value to the detector. Writing a matching data sequence therefore raises its interrupt.
- R9: `pwm_shutdown` is high whenever some line has its trip-enable bit set and its raw pin is low. This path has no clock stage in it.
- R10: On the synchronised fault condition, `irq_trip` pulses for one cycle, three edges after the pin falls. It does not pulse again until the fault has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr` (combinational) |
| pin_in | input | 12 | Raw pin levels |
| pin_out | output | 12 | Output drive values |
| pin_oe | output | 12 | Output enables |
| irq_mask | input | 5 | Bits 0-3 gate dedicated requests, bit 4 the shared request |
| irq_ded | output | 4 | Dedicated requests for lines 0-3 |
| irq_shared | output | 1 | Combined request for lines 4-11 |
| irq_trip | output | 1 | One-cycle trip interrupt |
| pwm_shutdown | output | 1 | Asynchronous PWM shutdown |

## Verification
Two functions can land in the same cycle: a software write-one-to-clear of a shared flag, and a new event on that same line. The bench drops line 4 and counts the clock edges so that its clear write is captured on the very edge that registers the falling-edge event. It then reads the flag register and expects bit 4 still set. A second clear with no event behind it must then read back 0, which shows that the earlier flag survived because of the collision and not because the clear had failed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_DIR  = 3'd0,
        RA_DATA = 3'd1,
        RA_MODE = 3'd2,
        RA_POL  = 3'd3,
        RA_SHEN = 3'd4,
        RA_FLAG = 3'd5,
        RA_TRIP = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIP_IDLE  = 2'd0,
        TRIP_PULSE = 2'd1,
        TRIP_HOLD  = 2'd2
    } trip_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_val,
    input  logic [WIDTH-1:0] level_mode,
    input  logic [WIDTH-1:0] polarity,
    output logic [WIDTH-1:0] event_hit
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line_val;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic rise_w;
        logic fall_w;
        assign rise_w = line_val[i] & ~prev_q[i];
        assign fall_w = ~line_val[i] & prev_q[i];
        always_comb begin
            if (level_mode[i]) event_hit[i] = (line_val[i] == polarity[i]);
            else               event_hit[i] = polarity[i] ? rise_w : fall_w;
        end
    end
endmodule

// File: rtl/gpio_trip_ctl.sv
module gpio_trip_ctl
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic trip_pulse
);
    trip_state_e state_q;
    trip_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIP_IDLE:  if (fault)  state_d = TRIP_PULSE;
            TRIP_PULSE: state_d = fault ? TRIP_HOLD : TRIP_IDLE;
            TRIP_HOLD:  if (!fault) state_d = TRIP_IDLE;
            default:    state_d = TRIP_IDLE;
        endcase
    end

    always_comb begin
        trip_pulse = 1'b0;
        unique case (state_q)
            TRIP_PULSE: trip_pulse = 1'b1;
            default:    trip_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_trip_bank.sv
module gpio_trip_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int NUM_DED   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    input  logic [NUM_DED:0]     irq_mask,
    output logic [NUM_DED-1:0]   irq_ded,
    output logic                 irq_shared,
    output logic                 irq_trip,
    output logic                 pwm_shutdown
);
    localparam int NUM_SH = NUM_LINES - NUM_DED;
    localparam logic [NUM_LINES-1:0] SH_LINES = {{NUM_SH{1'b1}}, {NUM_DED{1'b0}}};

    reg_addr_e            addr_e;
    logic [NUM_LINES-1:0] dir_q, dat_q, mode_q, pol_q, shen_q, trip_en_q, flag_q;
    logic [NUM_LINES-1:0] pin_sync, line_val, event_hit, flag_set, flag_clr;
    logic [NUM_DED-1:0]   ded_q;
    logic                 trip_fault;

    assign addr_e = reg_addr_e'(reg_addr);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            dat_q     <= '0;
            mode_q    <= '0;
            pol_q     <= '0;
            shen_q    <= '0;
            trip_en_q <= '0;
        end else if (reg_wr) begin
            case (addr_e)
                RA_DIR:  dir_q     <= reg_wdata;
                RA_DATA: dat_q     <= reg_wdata;
                RA_MODE: mode_q    <= reg_wdata;
                RA_POL:  pol_q     <= reg_wdata;
                RA_SHEN: shen_q    <= reg_wdata;
                RA_TRIP: trip_en_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    // outputs loop back into the detector
    assign line_val = (dir_q & dat_q) | (~dir_q & pin_sync);

    gpio_event_det #(.WIDTH(NUM_LINES)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_val   (line_val),
        .level_mode (mode_q),
        .polarity   (pol_q),
        .event_hit  (event_hit)
    );

    // sticky shared flags, set wins over clear
    assign flag_set = event_hit & shen_q & SH_LINES;
    assign flag_clr = (reg_wr && addr_e == RA_FLAG) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            ded_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            ded_q  <= event_hit[NUM_DED-1:0] & irq_mask[NUM_DED-1:0];
        end
    end

    assign irq_ded    = ded_q;
    assign irq_shared = irq_mask[NUM_DED] & (|flag_q);

    // fault path: raw pin, no clock stage
    assign pwm_shutdown = |(trip_en_q & ~pin_in);
    assign trip_fault   = |(trip_en_q & ~pin_sync);

    gpio_trip_ctl u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (trip_fault),
        .trip_pulse (irq_trip)
    );

    always_comb begin
        case (addr_e)
            RA_DIR:  reg_rdata = dir_q;
            RA_DATA: reg_rdata = line_val;
            RA_MODE: reg_rdata = mode_q;
            RA_POL:  reg_rdata = pol_q;
            RA_SHEN: reg_rdata = shen_q;
            RA_FLAG: reg_rdata = flag_q;
            RA_TRIP: reg_rdata = trip_en_q;
            default: reg_rdata = '0;
        endcase
    end

    assign pin_out = dat_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_trip_bank_chk.sv
module gpio_trip_bank_chk #(
    parameter int NUM_LINES = 12,
    parameter int NUM_DED   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [2:0]           reg_addr,
    input logic [NUM_LINES-1:0] reg_wdata,
    input logic [NUM_LINES-1:0] pin_in,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [NUM_DED:0]     irq_mask,
    input logic [NUM_DED-1:0]   irq_ded,
    input logic                 irq_shared,
    input logic                 irq_trip,
    input logic                 pwm_shutdown,
    input logic [NUM_LINES-1:0] flag_q
);
    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> (pin_oe == $past(reg_wdata))); // R2

    AST_DED_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ded != '0) |-> ((irq_ded & $past(irq_mask[NUM_DED-1:0])) == irq_ded)); // R5

    AST_SHARED_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> !irq_shared); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'd5) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7

    AST_NO_TRIP_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_in) |-> !pwm_shutdown); // R9

    AST_TRIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trip |=> !irq_trip); // R10
endmodule

bind gpio_trip_bank gpio_trip_bank_chk #(.NUM_LINES(NUM_LINES), .NUM_DED(NUM_DED)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .pin_in       (pin_in),
    .pin_oe       (pin_oe),
    .irq_mask     (irq_mask),
    .irq_ded      (irq_ded),
    .irq_shared   (irq_shared),
    .irq_trip     (irq_trip),
    .pwm_shutdown (pwm_shutdown),
    .flag_q       (flag_q)
);

// File: tb/gpio_trip_bank_tb.sv
module gpio_trip_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic [11:0] pin_in = 12'hFFF;
    logic [11:0] pin_out, pin_oe;
    logic [4:0]  irq_mask = 5'h00;
    logic [3:0]  irq_ded;
    logic        irq_shared, irq_trip, pwm_shutdown;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gpio_trip_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_mask(irq_mask),
        .irq_ded(irq_ded), .irq_shared(irq_shared), .irq_trip(irq_trip),
        .pwm_shutdown(pwm_shutdown)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [11:0] v;
        chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 irq_ded", int'(irq_ded), 0);
        chk("R1 irq_shared", int'(irq_shared), 0);
        chk("R1 irq_trip", int'(irq_trip), 0);
        chk("R1 pwm_shutdown", int'(pwm_shutdown), 0);
        rd(3'd5, v); chk("R1 flags", int'(v), 0);
    endtask

    task automatic t_data();
        logic [11:0] v;
        wr(3'd0, 12'h0F0);
        wr(3'd1, 12'hA5A);
        chk("R2 pin_oe", int'(pin_oe), 'h0F0);
        chk("R2 pin_out", int'(pin_out), 'hA5A);
        @(negedge clk); pin_in[0] = 1'b0;
        wait_n(3);
        rd(3'd1, v); chk("R2 data readback", int'(v), 'hF5E);
        wr(3'd0, 12'h000);
        pin_in[0] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_edge();
        irq_mask = 5'h1F;
        wr(3'd3, 12'h001);          // r3_: line0 rising, line1 falling
        wait_n(2);
        pin_in[0] = 1'b0;
        wait_n(3); chk("R3 wrong edge ignored", int'(irq_ded[0]), 0);
        pin_in[0] = 1'b1;
        wait_n(3); chk("R3 rising pulse", int'(irq_ded[0]), 1);
        wait_n(1); chk("R3 pulse one cycle", int'(irq_ded[0]), 0);
        pin_in[1] = 1'b0;
        wait_n(3); chk("R3 falling pulse", int'(irq_ded[1]), 1);
        wait_n(1); chk("R3 falling one cycle", int'(irq_ded[1]), 0);
        pin_in[1] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_level_mask();
        pin_in[2] = 1'b0;
        wait_n(5);
        wr(3'd2, 12'h00C);
        wr(3'd3, 12'h005);          // line2 active high, line3 active low
        wait_n(2);
        chk("R4 idle level", int'(irq_ded[3:2]), 0);
        pin_in[2] = 1'b1;
        wait_n(3); chk("R4 level high asserted", int'(irq_ded[2]), 1);
        wait_n(3); chk("R4 level held", int'(irq_ded[2]), 1);
        pin_in[3] = 1'b0;
        wait_n(3); chk("R4 active low asserted", int'(irq_ded[3]), 1);
        irq_mask = 5'h00;
        wait_n(1); chk("R5 mask clears ded", int'(irq_ded), 0);
        chk("R5 mask clears shared", int'(irq_shared), 0);
        irq_mask = 5'h1F;
        wait_n(1); chk("R5 unmask restores", int'(irq_ded[3:2]), 3);
        pin_in[2] = 1'b0;
        wait_n(3); chk("R4 level released", int'(irq_ded[2]), 0);
        wr(3'd2, 12'h000);
        wr(3'd3, 12'h000);
        pin_in[2] = 1'b1; pin_in[3] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_shared();
        logic [11:0] v;
        wr(3'd4, 12'h0F1);          // bit0 set but must be ignored
        wait_n(1);
        pin_in[0] = 1'b0; pin_in[5] = 1'b0; pin_in[8] = 1'b0;
        wait_n(3);
        rd(3'd5, v); chk("R6 only enabled shared line flags", int'(v), 'h020);
        chk("R6 shared irq", int'(irq_shared), 1);
        pin_in[0] = 1'b1; pin_in[5] = 1'b1; pin_in[8] = 1'b1;
        wait_n(4);
        rd(3'd5, v); chk("R7 flag sticky", int'(v), 'h020);
        wr(3'd5, 12'h020);
        rd(3'd5, v); chk("R7 w1c clears", int'(v), 0);
        chk("R6 shared irq drops", int'(irq_shared), 0);
    endtask

    task automatic t_w1c_level();
        logic [11:0] v;
        wr(3'd2, 12'h040);          // line6 level, active low
        pin_in[6] = 1'b0;
        wait_n(3);
        rd(3'd5, v); chk("R7 level flag", int'(v), 'h040);
        wr(3'd5, 12'h040);
        rd(3'd5, v); chk("R7 level re-sets after clear", int'(v), 'h040);
        wr(3'd2, 12'h000);
        wr(3'd5, 12'h040);
        rd(3'd5, v); chk("R7 clear after level gone", int'(v), 0);
        pin_in[6] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_collision();
        logic [11:0] v;
        @(negedge clk); pin_in[4] = 1'b0;
        wait_n(2);
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 12'h010;
        @(negedge clk); reg_wr = 1'b0;
        rd(3'd5, v); chk("R7 event beats same-cycle clear", int'(v), 'h010);
        wr(3'd5, 12'h010);
        rd(3'd5, v); chk("R7 plain clear", int'(v), 0);
        pin_in[4] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_loopback();
        wr(3'd1, 12'h002);
        wr(3'd0, 12'h002);
        wait_n(2);
        chk("R8 line1 driven", int'(pin_oe), 'h002);
        wr(3'd1, 12'h000);
        wait_n(1); chk("R8 output write raises irq", int'(irq_ded[1]), 1);
        wait_n(1); chk("R8 pulse ends", int'(irq_ded[1]), 0);
        wr(3'd0, 12'h000);
        wait_n(4);
    endtask

    task automatic t_trip();
        wr(3'd6, 12'h200);
        wait_n(1);
        pin_in[10] = 1'b0;
        #1 chk("R9 non-enabled line no trip", int'(pwm_shutdown), 0);
        pin_in[9] = 1'b0;
        #1 chk("R9 immediate shutdown", int'(pwm_shutdown), 1);
        wait_n(3); chk("R10 trip pulse", int'(irq_trip), 1);
        wait_n(1); chk("R10 single pulse", int'(irq_trip), 0);
        wait_n(3); chk("R10 no repeat while held", int'(irq_trip), 0);
        chk("R9 shutdown held", int'(pwm_shutdown), 1);
        pin_in[9] = 1'b1;
        #1 chk("R9 shutdown releases", int'(pwm_shutdown), 0);
        wait_n(4);
        pin_in[9] = 1'b0;
        wait_n(3); chk("R10 second trip pulse", int'(irq_trip), 1);
        wr(3'd6, 12'h000);
        #1 chk("R9 disabled trip", int'(pwm_shutdown), 0);
        pin_in[9] = 1'b1; pin_in[10] = 1'b1;
        wait_n(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_n(3);
        t_data();
        t_edge();
        t_level_mask();
        t_shared();
        t_w1c_level();
        t_collision();
        t_loopback();
        t_trip();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule